// File: doc/BRIEF.md
# JTAG Scan Register Access Port

This block turns a test-data register of a JTAG TAP into an access port for a small synchronous register space. A 40-bit scan chain carries a 32-bit data word, a 7-bit register address and a direction flag. When the TAP reaches Update-DR, the block issues exactly one write or one read on a simple register bus. The TAP state machine and the instruction decoder stay outside the block. A single select input tells the block that the register-access instruction is loaded; every TAP strobe is ignored while that input is low.

Reads are pipelined. A read scan only launches the bus read. The read result is held inside the block and loaded into the data field at the next Capture-DR, so it is shifted out during the following scan. Software therefore finishes a run of reads with one last read of a side-effect-free address, such as the identification register at address 0. That last read collects the previous result and does not pop another word from a destructive port, such as the trace RAM data port at address 4.

Top module: `scan_reg_bridge`

## Requirements
- R1: After a synchronous active-low reset, bus_we and bus_re are 0, tdo is 0 and the held read result is 0. The first capture after reset therefore shifts out 40 zero bits.
- R2: While sel and shift_dr are high, the chain moves one bit per clock toward tdo. tdi enters at bit 39 and tdo shows bit 0. Bits are shifted LSB first.
- R3: An update_dr with sel high and chain bit 39 = 1 drives bus_we high for exactly one clock, starting the cycle after the update. In that cycle bus_addr carries chain bits 38:32 and bus_wdata carries bits 31:0.
- R4: An update_dr with sel high and bit 39 = 0 drives bus_re high for exactly one clock, starting the cycle after the update, with bus_addr taken from bits 38:32.
- R5: bus_rdata is sampled at the clock edge that ends the cycle after bus_re was high. The sampled value is kept until the next read.
- R6: A capture_dr with sel high loads the held read result into bits 31:0 and zeros into bits 39:32.
- R7: A scan shifts out the result of the read launched by the most recent earlier read scan. Write scans in between leave that result unchanged.
- R8: While sel is low, capture_dr, shift_dr and update_dr have no effect: the chain is frozen, no bus strobe is issued and tdo is 0.
- R9: bus_we and bus_re are never high together. Each update issues one access, so a destructive read address is read only once per read scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Register-access instruction is active |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0, 0 when not selected) |
| bus_addr | output | 7 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read data, valid the cycle after bus_re |

## Verification
The hardest cases to reach from the ports are the one-scan lag of reads and the single pop of a destructive port. To reach them, the bench fills a FIFO-like register behind address 4 through write scans. It then drains the FIFO with back-to-back read scans, finishes with a read of address 0, and checks both each collected word and the exact number of pops. It also tests that a deselected TAP has no effect. To do this, it interrupts a write scan between its last shift and its update with a burst of deselected strobes, then checks that the original payload still lands in the register.

// File: rtl/scan_bridge_pkg.sv
// Shared constants and types for the scan register access port.
package scan_bridge_pkg;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_ADDR_W = 7;

    // Direction flag carried in the top bit of the scan chain.
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/scan_shift_chain.sv
// Serial scan chain. It loads the held read result on capture and shifts
// LSB first toward tdo.
// Assumes: capture has priority over shift; all strobes are qualified by sel.
module scan_shift_chain #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TOT_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              tdi,
    input  logic [DATA_W-1:0] load_val,
    output logic [TOT_W-1:0]  chain
);
    localparam int unsigned HDR_W = TOT_W - DATA_W;

    // Purpose: capture the read result or move the chain by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (sel) begin
            if (capture) begin
                chain <= {{HDR_W{1'b0}}, load_val};
            end else if (shift) begin
                chain <= {tdi, chain[TOT_W-1:1]};
            end
        end
    end

    AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(chain)); // R8
    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift && !capture) |=> (chain[TOT_W-2:0] == $past(chain[TOT_W-1:1]))); // R2
endmodule

// File: rtl/scan_access_decode.sv
// Decodes the chain on update into one registered bus write or read strobe.
// Assumes: the chain is stable during the update cycle.
module scan_access_decode
    import scan_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned TOT_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              update,
    input  logic [TOT_W-1:0]  chain,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re
);
    acc_kind_e kind;

    // Purpose: name the direction flag.
    always_comb kind = acc_kind_e'(chain[TOT_W-1]);

    // Purpose: issue one strobe for each selected update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
        end else begin
            bus_we <= 1'b0;
            bus_re <= 1'b0;
            if (sel && update) begin
                bus_addr <= chain[DATA_W +: ADDR_W];
                if (kind == ACC_WRITE) begin
                    bus_we    <= 1'b1;
                    bus_wdata <= chain[DATA_W-1:0];
                end else begin
                    bus_re <= 1'b1;
                end
            end
        end
    end

    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re)); // R9
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we); // R3
    AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re); // R4
    AST_STROBE_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |-> $past(sel && update)); // R8
endmodule

// File: rtl/scan_read_hold.sv
// Samples bus read data one cycle after the read strobe and holds it
// for the next capture.
// Assumes: the bus target returns data the cycle after bus_re.
module scan_read_hold #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] held
);
    logic re_dly;

    // Purpose: delay the read strobe to the bus data-valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) re_dly <= 1'b0;
        else        re_dly <= bus_re;
    end

    // Purpose: keep the most recent read result.
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (re_dly) held <= bus_rdata;
    end

    AST_HOLD_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(held)) |-> $past(bus_re, 2)); // R5
endmodule

// File: rtl/scan_reg_bridge.sv
// Top of the scan register access port: chain, decode and read hold.
// Assumes: TAP strobes are one-hot and synchronous to clk. At least two
// clocks pass between Update-DR and the next Capture-DR.
module scan_reg_bridge
    import scan_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned TOT_W = DATA_W + ADDR_W + 1;

    logic [TOT_W-1:0]  chain;
    logic [DATA_W-1:0] held;

    scan_shift_chain #(.DATA_W(DATA_W), .TOT_W(TOT_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .sel(sel), .capture(capture_dr),
        .shift(shift_dr), .tdi(tdi), .load_val(held), .chain(chain)
    );

    scan_access_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOT_W(TOT_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel(sel), .update(update_dr), .chain(chain),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re)
    );

    scan_read_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_rdata(bus_rdata), .held(held)
    );

    // Purpose: drive the serial output only while selected.
    always_comb tdo = sel ? chain[0] : 1'b0;

    AST_CAPTURE_HDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture_dr) |=> (chain[TOT_W-1:DATA_W] == '0)); // R6
endmodule

// File: tb/scan_reg_bridge_bench.sv
module scan_reg_bridge_bench;
    localparam logic [31:0] ID_VAL = 32'h1AB0_0C0D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic tdo, bus_we, bus_re;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scan_reg_bridge u_scan_reg_bridge (
        .clk(clk), .rst_n(rst_n), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    // Bus target: address 0 = ID, address 4 = FIFO port, others plain registers.
    logic [31:0] regs [0:127];
    logic [31:0] fifo [$];
    int pops = 0, writes = 0;
    always @(posedge clk) begin
        if (bus_we) begin
            writes++;
            if (bus_addr == 7'd4) fifo.push_back(bus_wdata);
            else regs[bus_addr] = bus_wdata;
        end
        if (bus_re) begin
            if (bus_addr == 7'd0) bus_rdata <= ID_VAL;
            else if (bus_addr == 7'd4) begin
                pops++;
                if (fifo.size() > 0) bus_rdata <= fifo.pop_front();
                else bus_rdata <= 32'hDEAD_0000;
            end else bus_rdata <= regs[bus_addr];
        end
    end

    // Behavioural reference model.
    bit m_sr [$];
    bit m_we, m_re, m_redly;
    logic [6:0] m_addr;
    logic [31:0] m_wdata, m_hold;
    always @(posedge clk) begin
        logic [31:0] old_hold;
        if (!rst_n) begin
            m_sr.delete();
            for (int i = 0; i < 40; i++) m_sr.push_back(1'b0);
            m_we = 0; m_re = 0; m_redly = 0; m_hold = '0; m_addr = '0; m_wdata = '0;
        end else begin
            old_hold = m_hold;
            if (m_redly) m_hold = bus_rdata;
            m_redly = m_re;
            m_we = 0; m_re = 0;
            if (sel) begin
                if (update_dr) begin
                    for (int i = 0; i < 7; i++) m_addr[i] = m_sr[32+i];
                    if (m_sr[39]) begin
                        m_we = 1;
                        for (int i = 0; i < 32; i++) m_wdata[i] = m_sr[i];
                    end else m_re = 1;
                end
                if (capture_dr) begin
                    m_sr.delete();
                    for (int i = 0; i < 40; i++) m_sr.push_back(i < 32 ? old_hold[i] : 1'b0);
                end else if (shift_dr) begin
                    void'(m_sr.pop_front());
                    m_sr.push_back(tdi);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare against the model, then drive the next inputs.
    task automatic step(input logic sl, input logic c, input logic s, input logic u,
                        input logic t, output logic obs);
        @(negedge clk);
        obs = tdo;
        chk(tdo === (sel ? m_sr[0] : 1'b0), "R2/R8 tdo", {39'b0, tdo}, {39'b0, sel ? m_sr[0] : 1'b0});
        chk(bus_we === m_we, "R3 bus_we", {39'b0, bus_we}, {39'b0, m_we});
        chk(bus_re === m_re, "R4 bus_re", {39'b0, bus_re}, {39'b0, m_re});
        if (m_we) chk(bus_wdata === m_wdata && bus_addr === m_addr, "R3 write fields",
                      {1'b0, bus_addr, bus_wdata}, {1'b0, m_addr, m_wdata});
        if (m_re) chk(bus_addr === m_addr, "R4 read addr", {33'b0, bus_addr}, {33'b0, m_addr});
        chk(!(bus_we && bus_re), "R9 exclusive strobes", {38'b0, bus_we, bus_re}, 40'b0);
        sel = sl; capture_dr = c; shift_dr = s; update_dr = u; tdi = t;
    endtask

    task automatic scan(input bit rnw_w, input logic [6:0] a, input logic [31:0] d,
                        input bit interfere, output logic [39:0] got);
        logic [39:0] v;
        logic o;
        v = {rnw_w, a, d};
        step(1, 1, 0, 0, 0, o);
        for (int i = 0; i < 40; i++) begin
            step(1, 0, 1, 0, v[i], o);
            got[i] = o;
        end
        step(1, 0, 0, 0, 0, o);
        if (interfere) begin
            for (int i = 0; i < 24; i++) step(0, i % 5 == 0, 1, i % 7 == 3, 1, o);
            step(1, 0, 0, 0, 0, o);
        end
        step(1, 0, 0, 1, 0, o);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, o);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [39:0] g;
        logic o;
        int w0;
        for (int i = 0; i < 128; i++) regs[i] = '0;
        repeat (4) step(0, 0, 0, 0, 0, o);
        rst_n = 1'b1;
        step(1, 0, 0, 0, 0, o);

        scan(0, 7'd0, 32'h0, 0, g);               // R1: reset hold is zero
        chk(g === 40'h0, "R1 reset capture", g, 40'h0);
        scan(1, 7'd9, 32'hA5A5_1234, 0, g);       // R7: collects ID from previous read
        chk(g[31:0] === ID_VAL, "R7 pipelined ID", g, {8'h0, ID_VAL});
        chk(g[39:32] === 8'h0, "R6 header zero", g, {8'h0, g[31:0]});
        scan(1, 7'd10, 32'h0BAD_F00D, 0, g);      // R7: write scan keeps held value
        chk(g[31:0] === ID_VAL, "R7 held over write", g, {8'h0, ID_VAL});
        chk(regs[9] === 32'hA5A5_1234, "R3 write landed", {8'h0, regs[9]}, 40'hA5A5_1234);
        scan(0, 7'd9, 32'h0, 0, g);
        chk(g[31:0] === ID_VAL, "R7 still ID", g, {8'h0, ID_VAL});
        scan(0, 7'd10, 32'h0, 0, g);
        chk(g[31:0] === 32'hA5A5_1234, "R5 reg9 value", g, 40'hA5A5_1234);
        scan(0, 7'd0, 32'h0, 0, g);
        chk(g[31:0] === 32'h0BAD_F00D, "R5 reg10 value", g, 40'h0BAD_F00D);

        scan(1, 7'd4, 32'h11, 0, g);
        chk(g[31:0] === ID_VAL, "R6 capture of ID", g, {8'h0, ID_VAL});
        scan(1, 7'd4, 32'h22, 0, g);
        scan(1, 7'd4, 32'h33, 0, g);
        scan(0, 7'd4, 32'h0, 0, g);
        scan(0, 7'd4, 32'h0, 0, g);
        chk(g[31:0] === 32'h11, "R7 fifo word0", g, 40'h11);
        scan(0, 7'd4, 32'h0, 0, g);
        chk(g[31:0] === 32'h22, "R7 fifo word1", g, 40'h22);
        scan(0, 7'd0, 32'h0, 0, g);               // final read of a side-effect-free address
        chk(g[31:0] === 32'h33, "R7 fifo word2", g, 40'h33);
        chk(pops == 3 && fifo.size() == 0, "R9 single pop per read", pops, 3);
        scan(0, 7'd0, 32'h0, 0, g);
        chk(g[31:0] === ID_VAL, "R5 closing ID", g, {8'h0, ID_VAL});

        w0 = writes;                              // R8: deselected strobes ignored
        scan(1, 7'd12, 32'hCAFE_5A5A, 1, g);
        chk(writes == w0 + 1, "R8 one write only", writes, w0 + 1);
        chk(regs[12] === 32'hCAFE_5A5A, "R8 payload intact", {8'h0, regs[12]}, 40'hCAFE_5A5A);
        scan(0, 7'd12, 32'h0, 0, g);
        chk(g[31:0] === ID_VAL, "R8 hold intact", g, {8'h0, ID_VAL});
        scan(0, 7'd0, 32'h0, 0, g);
        chk(g[31:0] === 32'hCAFE_5A5A, "R5 reg12 readback", g, 40'hCAFE_5A5A);
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 1, o);
        chk(o === 1'b0, "R8 tdo idle", {39'b0, o}, 40'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule